// File: doc/BRIEF.md
# Framed Serial Word Receiver with Lock Detection

This block takes a serial bit stream made of fixed 12-bit frames and turns it back into 10-bit words. Bits arrive one per cycle in which the bit-enable input is high. The enable runs on the local clock and can come from an oversampling phase picker or a plain bit-rate divider. The receiver has to find where frames begin before it can pass any data on. It can do this in two ways. It can spot a training burst of six ones followed by six zeros. It can also hunt through live traffic until the start and stop bits land where they should, frame after frame, at the same bit offset.

While alignment is being sought, an active-low lock flag is high and no words come out. Once the receiver is aligned, the flag goes low. Every frame that is well formed then produces one word with a one-cycle valid strobe. Repeated framing errors mean the alignment was wrong or has been lost. In that case the receiver drops the flag and returns to the hunt by itself. Two level inputs, a receive enable and an active-low power-down, are both held high for normal continuous operation.

Top module: `ser_frame_rx`

## Requirements
- R1: After reset, `lock_n` is 1 and `word_vld` is 0.
- R2: A frame is 12 bits in arrival order: a start bit of 1, data bits d0 (first) through d9, and a stop bit of 0. When a well-formed frame completes while the receiver is locked, `word` holds the data bits with d0 at bit 0, and `word_vld` is high for exactly the one cycle after the clock edge that took the stop bit.
- R3: While searching, the twelve most recent bits matching six 1s followed by six 0s makes `lock_n` go low on the edge that took the last 0. The next bit is then treated as a start bit. This check does not depend on the current candidate offset.
- R4: While searching, four consecutive well-formed frames at the same offset make `lock_n` go low on the edge of the fourth stop bit. After only three such frames, `lock_n` is still 1.
- R5: While searching, a failed start/stop check moves the candidate frame boundary one bit later, so the next check happens on the very next bit. Lock is reached from any starting bit offset.
- R6: While `lock_n` is 1, `word_vld` stays 0. Frames used to acquire lock produce no word.
- R7: While locked, a single badly framed frame gives no `word_vld` and keeps `lock_n` low. The boundary is kept, so the next well-formed frame is delivered.
- R8: While locked, two consecutive badly framed frames make `lock_n` go high on the edge that took the second bad stop bit.
- R9: After lock is lost, the receiver searches again and relocks on the following framed traffic with no outside action.
- R10: While `pwr_dn_n` is 0, the receiver is forced to search state, `lock_n` is 1 from the next edge on, and incoming bits are ignored. This includes a training burst.
- R11: While `rx_en` is 0, `word_vld` stays 0 but frame alignment and lock are kept. The first frame after `rx_en` returns high is delivered correctly.
- R12: A training burst received while already locked is handled as an ordinary frame and is delivered as word 10'h01F.
- R13: `word_vld` only rises on an edge where `bit_en` was high, and it never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | High for one cycle per received bit |
| ser_in | input | 1 | Serial data bit, sampled when `bit_en` is high |
| rx_en | input | 1 | Receive enable; low suppresses word output |
| pwr_dn_n | input | 1 | Active-low power-down; low clears alignment and ignores bits |
| word | output | 10 | Last recovered data word, d0 at bit 0 |
| word_vld | output | 1 | One-cycle strobe for a new `word` |
| lock_n | output | 1 | Active-low lock indicator |

## Verification
The bench starts a frame stream several bits off the true boundary and built from all-zero words. This makes exactly one offset legal, so a receiver that skipped bits while sliding, or that waited a full frame after each failure, would lock late or on the wrong boundary. It sends exactly three good frames and then a fourth, to catch a lock counter that is off by one. It also sends one bad frame between good ones and then two in a row, to separate the tolerated error from real loss; a receiver that dropped lock too early would lose the next word. Last, it sends a training burst during power-down, with the receive enable low, and again while locked. A receiver that still listened while powered down, lost alignment while gated, or treated an in-lock burst as a realignment would show a wrong lock flag or a missing 10'h01F word.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    typedef enum logic [0:0] {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } link_st_e;

endpackage

// File: rtl/dsr_shift.sv
// Bit history: keeps the last FRAME_W-1 accepted bits and presents them,
// together with the bit now on the line, as a full frame window.
module dsr_shift #(
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               bit_en,
    input  logic               ser_in,
    output logic [FRAME_W-1:0] win
);

    localparam int HIST_W = FRAME_W - 1;

    logic [HIST_W-1:0] hist_d;
    logic [HIST_W-1:0] hist_q;

    // oldest bit at the MSB, the bit being taken now at bit 0
    assign win = {hist_q, ser_in};

    always_comb begin
        hist_d = hist_q;
        if (clr) begin
            hist_d = '0;
        end else if (bit_en) begin
            hist_d = win[HIST_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

endmodule

// File: rtl/dsr_frame_chk.sv
// Pure decode of one frame window: start/stop check, training burst match
// and data extraction (first data bit on the line lands at bit 0).
module dsr_frame_chk #(
    parameter int FRAME_W   = 12,
    parameter int TRAIN_RUN = 6
) (
    input  logic [FRAME_W-1:0] win,
    output logic               frame_ok,
    output logic               train_hit,
    output logic [FRAME_W-3:0] data
);

    localparam int DATA_W = FRAME_W - 2;
    // TRAIN_RUN ones (oldest) followed by zeros (newest)
    localparam logic [FRAME_W-1:0] TRAIN_PAT = ~({FRAME_W{1'b1}} >> TRAIN_RUN);

    assign frame_ok  = win[FRAME_W-1] & ~win[0];
    assign train_hit = (win == TRAIN_PAT);

    for (genvar i = 0; i < DATA_W; i++) begin : g_data
        assign data[i] = win[FRAME_W-2-i];
    end

endmodule

// File: rtl/dsr_lock_fsm.sv
// Alignment search, lock keeping and word delivery.
module dsr_lock_fsm
    import dsr_pkg::*;
#(
    parameter int FRAME_W     = 12,
    parameter int LOCK_FRAMES = 4,
    parameter int LOSS_FRAMES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_ok,
    input  logic               rx_en,
    input  logic               bit_en,
    input  logic               frame_ok,
    input  logic               train_hit,
    input  logic [FRAME_W-3:0] data,
    output logic               lock_n,
    output logic               word_vld,
    output logic [FRAME_W-3:0] word
);

    localparam int DATA_W = FRAME_W - 2;
    localparam int POS_W  = $clog2(FRAME_W);
    localparam int GOOD_W = $clog2(LOCK_FRAMES + 1);
    localparam int ERR_W  = $clog2(LOSS_FRAMES + 1);

    localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(FRAME_W - 1);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_FRAMES - 1);
    localparam logic [ERR_W-1:0]  ERR_LAST  = ERR_W'(LOSS_FRAMES - 1);

    typedef struct packed {
        link_st_e          st;
        logic [POS_W-1:0]  pos;
        logic [GOOD_W-1:0] good;
        logic [ERR_W-1:0]  errs;
        logic              vld;
        logic [DATA_W-1:0] word;
    } fsm_t;

    fsm_t s_d;
    fsm_t s_q;

    logic at_end;
    assign at_end = (s_q.pos == POS_LAST);

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (!pwr_ok) begin
            s_d.st   = ST_HUNT;
            s_d.pos  = '0;
            s_d.good = '0;
            s_d.errs = '0;
        end else if (bit_en) begin
            unique case (s_q.st)
                ST_HUNT: begin
                    if (train_hit) begin
                        s_d.st   = ST_LOCKED;
                        s_d.pos  = '0;
                        s_d.good = '0;
                        s_d.errs = '0;
                    end else if (at_end) begin
                        if (frame_ok) begin
                            s_d.pos = '0;
                            if (s_q.good == GOOD_LAST) begin
                                s_d.st   = ST_LOCKED;
                                s_d.good = '0;
                                s_d.errs = '0;
                            end else begin
                                s_d.good = s_q.good + 1'b1;
                            end
                        end else begin
                            // slide: keep pos at the end so the next bit is checked
                            s_d.good = '0;
                        end
                    end else begin
                        s_d.pos = s_q.pos + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (at_end) begin
                        if (frame_ok) begin
                            s_d.pos  = '0;
                            s_d.errs = '0;
                            if (rx_en) begin
                                s_d.vld  = 1'b1;
                                s_d.word = data;
                            end
                        end else if (s_q.errs == ERR_LAST) begin
                            s_d.st   = ST_HUNT;
                            s_d.pos  = POS_LAST;
                            s_d.good = '0;
                            s_d.errs = '0;
                        end else begin
                            s_d.pos  = '0;
                            s_d.errs = s_q.errs + 1'b1;
                        end
                    end else begin
                        s_d.pos = s_q.pos + 1'b1;
                    end
                end
                default: s_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= ST_HUNT;
            s_q.pos  <= '0;
            s_q.good <= '0;
            s_q.errs <= '0;
            s_q.vld  <= 1'b0;
            s_q.word <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lock_n   = (s_q.st != ST_LOCKED);
    assign word_vld = s_q.vld;
    assign word     = s_q.word;

    AST_VLD_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> !lock_n); // R6

    AST_VLD_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_vld) |-> $past(bit_en)); // R13

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld); // R13

    AST_PWR_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> lock_n); // R10

    AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !word_vld); // R11

    AST_LOCK_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> $past(bit_en && pwr_ok)); // R3

    AST_ERR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.errs < ERR_W'(LOSS_FRAMES)); // R8

endmodule

// File: rtl/ser_frame_rx.sv
module ser_frame_rx #(
    parameter int FRAME_W     = 12,
    parameter int TRAIN_RUN   = 6,
    parameter int LOCK_FRAMES = 4,
    parameter int LOSS_FRAMES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               ser_in,
    input  logic               rx_en,
    input  logic               pwr_dn_n,
    output logic [FRAME_W-3:0] word,
    output logic               word_vld,
    output logic               lock_n
);

    localparam int DATA_W = FRAME_W - 2;

    logic [FRAME_W-1:0] win;
    logic               frame_ok;
    logic               train_hit;
    logic [DATA_W-1:0]  data;
    logic               take_bit;

    // bits are dropped entirely while powered down
    assign take_bit = bit_en & pwr_dn_n;

    dsr_shift #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (~pwr_dn_n),
        .bit_en (take_bit),
        .ser_in (ser_in),
        .win    (win)
    );

    dsr_frame_chk #(
        .FRAME_W   (FRAME_W),
        .TRAIN_RUN (TRAIN_RUN)
    ) u_chk (
        .win       (win),
        .frame_ok  (frame_ok),
        .train_hit (train_hit),
        .data      (data)
    );

    dsr_lock_fsm #(
        .FRAME_W     (FRAME_W),
        .LOCK_FRAMES (LOCK_FRAMES),
        .LOSS_FRAMES (LOSS_FRAMES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (pwr_dn_n),
        .rx_en     (rx_en),
        .bit_en    (take_bit),
        .frame_ok  (frame_ok),
        .train_hit (train_hit),
        .data      (data),
        .lock_n    (lock_n),
        .word_vld  (word_vld),
        .word      (word)
    );

    AST_RESET_UNLOCKED: assert property (@(posedge clk)
        !rst_n |=> lock_n); // R1

endmodule

// File: tb/ser_frame_rx_bench.sv
module ser_frame_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       ser_in = 1'b0;
    logic       rx_en = 1'b1;
    logic       pwr_dn_n = 1'b1;
    logic [9:0] word;
    logic       word_vld;
    logic       lock_n;

    int checks = 0;
    int errors = 0;
    int vld_cnt = 0;
    logic [9:0] last_word = '0;

    always #4 clk = ~clk;

    ser_frame_rx u_ser_frame_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .ser_in   (ser_in),
        .rx_en    (rx_en),
        .pwr_dn_n (pwr_dn_n),
        .word     (word),
        .word_vld (word_vld),
        .lock_n   (lock_n)
    );

    always @(negedge clk) begin
        if (word_vld) begin
            vld_cnt   <= vld_cnt + 1;
            last_word <= word;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; ser_in = 1'b0; rx_en = 1'b1; pwr_dn_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_in = b; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        #1;
    endtask

    task automatic send_frame(input logic [9:0] d, input logic stop_good);
        send_bit(1'b1);
        for (int i = 0; i < 10; i++) send_bit(d[i]);
        send_bit(stop_good ? 1'b0 : 1'b1);
    endtask

    task automatic send_train();
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        for (int i = 0; i < 6; i++) send_bit(1'b0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 lock_n after reset", lock_n, 1);
        chk("R1 word_vld after reset", word_vld, 0);
    endtask

    task automatic t_training();
        int base;
        do_reset();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        send_train();
        chk("R3 lock after training", lock_n, 0);
        chk("R6 no word from training", vld_cnt, 0);
        base = vld_cnt;
        send_frame(10'h2B4, 1'b1);
        chk("R2 one strobe per frame", vld_cnt - base, 1);
        chk("R2 word value", last_word, 10'h2B4);
        send_frame(10'h0F3, 1'b1);
        chk("R2 second word", last_word, 10'h0F3);
    endtask

    task automatic t_random();
        int base;
        do_reset();
        base = vld_cnt;
        send_frame(10'h155, 1'b1);
        send_frame(10'h0A3, 1'b1);
        send_frame(10'h2C1, 1'b1);
        chk("R4 no lock after three frames", lock_n, 1);
        send_frame(10'h111, 1'b1);
        chk("R4 lock on fourth frame", lock_n, 0);
        chk("R6 acquisition frames silent", vld_cnt - base, 0);
        send_frame(10'h3C5, 1'b1);
        chk("R4 first word after random lock", last_word, 10'h3C5);
    endtask

    task automatic t_slide();
        do_reset();
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_frame(10'h000, 1'b1);
        chk("R5 lock from offset stream", lock_n, 0);
        send_frame(10'h2B4, 1'b1);
        chk("R5 aligned word", last_word, 10'h2B4);
    endtask

    task automatic t_errors();
        int base;
        do_reset();
        send_train();
        send_frame(10'h155, 1'b1);
        base = vld_cnt;
        send_frame(10'h000, 1'b0);
        chk("R7 lock held after one error", lock_n, 0);
        chk("R7 no word for bad frame", vld_cnt - base, 0);
        send_frame(10'h0F3, 1'b1);
        chk("R7 word after single error", last_word, 10'h0F3);
        base = vld_cnt;
        send_frame(10'h000, 1'b0);
        send_frame(10'h000, 1'b0);
        chk("R8 lock lost after two errors", lock_n, 1);
        chk("R8 no words for bad frames", vld_cnt - base, 0);
        for (int i = 0; i < 10; i++) send_frame(10'h000, 1'b1);
        chk("R9 relocked by itself", lock_n, 0);
        send_frame(10'h1E7, 1'b1);
        chk("R9 word after relock", last_word, 10'h1E7);
    endtask

    task automatic t_power();
        int base;
        do_reset();
        send_train();
        @(negedge clk);
        pwr_dn_n = 1'b0;
        @(negedge clk); #1;
        chk("R10 lock dropped in power-down", lock_n, 1);
        send_train();
        chk("R10 training ignored in power-down", lock_n, 1);
        @(negedge clk);
        pwr_dn_n = 1'b1;
        send_train();
        chk("R10 lock after power-up", lock_n, 0);
        @(negedge clk);
        rx_en = 1'b0;
        base = vld_cnt;
        send_frame(10'h2B4, 1'b1);
        chk("R11 no word while rx_en low", vld_cnt - base, 0);
        chk("R11 lock kept while rx_en low", lock_n, 0);
        @(negedge clk);
        rx_en = 1'b1;
        send_frame(10'h1E7, 1'b1);
        chk("R11 word after rx_en high", last_word, 10'h1E7);
    endtask

    task automatic t_train_locked();
        int base;
        do_reset();
        send_train();
        base = vld_cnt;
        send_train();
        chk("R12 burst while locked gives a word", vld_cnt - base, 1);
        chk("R12 burst word value", last_word, 10'h01F);
        chk("R12 lock kept", lock_n, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_training();
        t_random();
        t_slide();
        t_errors();
        t_power();
        t_train_locked();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule